// File: doc/BRIEF.md
# Linear Page Table Walker

This block services a translation miss in hardware when the operating system keeps its page-table entries in one flat, virtually mapped array. Given the virtual address that missed, it forms the virtual address of the matching 8-byte entry. That address keeps the region bits of the missing address. Its low part is a configured table base plus the scaled page number, truncated to the configured table size. The block knows nothing about how software arranges its tables beyond this flat indexing.

The entry address is itself virtual, so the walker sends it back through the ordinary TLB lookup port. On a hit it reads the entry from physical memory and either requests its installation as the translation for the original address or, if the entry is marked absent, reports a fault. On a lookup miss it does not recurse further. It reports a nested-translation fault and leaves the rest to software. The block works on one miss at a time.

Top module: `lpt_walker`

## Requirements
- R1: While and right after reset, `miss_ready` is high and `lk_req`, `rd_req`, `ins_valid` and `flt_valid` are all low.
- R2: For an accepted miss address `va`, `lk_va` is `{va[47:45], cfg_base + ((va[44:13] * 8) & mask)}`. The top three bits are the region and are copied unchanged. The sum is truncated to 45 bits.
- R3: `mask` is `2**cfg_size_log2 - 1`, so entry-offset bits at or above `cfg_size_log2` are dropped. A `cfg_size_log2` of 45 or more leaves the offset untruncated.
- R4: A lookup response with `lk_hit` low makes `flt_valid` pulse for one cycle in the cycle after the response. `flt_cause` is 2'b01 and `flt_va` is the original miss address. No memory read is issued.
- R5: A lookup response with `lk_hit` high makes `rd_req` rise in the next cycle with `rd_addr = {lk_ppn, lk_va[12:0]}`.
- R6: A read response whose bit 0 (present) is 1 makes `ins_valid` pulse for one cycle in the next cycle, with `ins_va` equal to the original miss address and `ins_pte` equal to the returned data.
- R7: A read response whose bit 0 is 0 makes `flt_valid` pulse in the next cycle with `flt_cause` 2'b10 and `flt_va` equal to the original miss address.
- R8: `miss_ready` is low from the cycle after a miss is accepted until its outcome pulse. It is high in the outcome cycle, so a waiting miss is accepted at the end of that cycle.
- R9: Each accepted miss yields exactly one outcome, in acceptance order, and `ins_valid` and `flt_valid` are never high together.
- R10: `lk_req` stays high with `lk_va` unchanged until `lk_rsp_valid` is seen. `rd_req` stays high with `rd_addr` unchanged until `rd_valid` is seen. Response latency may be any number of cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| miss_valid | input | 1 | A translation miss is offered |
| miss_ready | output | 1 | Walker idle; miss accepted when both high |
| miss_va | input | 48 | Virtual address that missed |
| cfg_base | input | 45 | Table base offset inside the region |
| cfg_size_log2 | input | 6 | Log2 of the table size in bytes |
| lk_req | output | 1 | Lookup request for the entry address |
| lk_va | output | 48 | Virtual address of the entry |
| lk_rsp_valid | input | 1 | Lookup response present |
| lk_hit | input | 1 | Lookup found a translation |
| lk_ppn | input | 27 | Physical page number on a hit |
| rd_req | output | 1 | Memory read request |
| rd_addr | output | 40 | Physical address of the entry |
| rd_valid | input | 1 | Read data present |
| rd_data | input | 64 | Entry read from memory |
| ins_valid | output | 1 | Install request pulse |
| ins_va | output | 48 | Address whose translation is installed |
| ins_pte | output | 64 | Entry to install |
| flt_valid | output | 1 | Fault pulse |
| flt_va | output | 48 | Address that faulted |
| flt_cause | output | 2 | 01 nested lookup miss, 10 entry absent |

## Verification
Two events can share a cycle: the outcome pulse of one walk, whether an install or a fault, and the acceptance of the next miss. The bench provokes this by offering the next miss while the walker is still busy, with zero-latency responders, so `miss_valid` is already high when the outcome appears. In every outcome cycle with `miss_valid` high, the monitor requires `miss_ready` to be high. The scoreboard then confirms that the following walk uses the new address and that no outcome is lost, doubled or reordered.

// File: rtl/lpt_walker.sv
module lpt_walker #(
  parameter int VA_W        = 48,
  parameter int REGION_W    = 3,
  parameter int PAGE_SHIFT  = 13,
  parameter int PA_W        = 40,
  parameter int PTE_W       = 64,
  parameter int LOG_W       = 6,
  parameter int PTE_SHIFT   = 3,
  parameter int PRESENT_BIT = 0
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       miss_valid,
  output logic                       miss_ready,
  input  logic [VA_W-1:0]            miss_va,
  input  logic [VA_W-REGION_W-1:0]   cfg_base,
  input  logic [LOG_W-1:0]           cfg_size_log2,
  output logic                       lk_req,
  output logic [VA_W-1:0]            lk_va,
  input  logic                       lk_rsp_valid,
  input  logic                       lk_hit,
  input  logic [PA_W-PAGE_SHIFT-1:0] lk_ppn,
  output logic                       rd_req,
  output logic [PA_W-1:0]            rd_addr,
  input  logic                       rd_valid,
  input  logic [PTE_W-1:0]           rd_data,
  output logic                       ins_valid,
  output logic [VA_W-1:0]            ins_va,
  output logic [PTE_W-1:0]           ins_pte,
  output logic                       flt_valid,
  output logic [VA_W-1:0]            flt_va,
  output logic [1:0]                 flt_cause
);

  localparam int OFF_W = VA_W - REGION_W;

  localparam logic [1:0] CAUSE_NESTED = 2'b01;
  localparam logic [1:0] CAUSE_ABSENT = 2'b10;

  typedef enum logic [1:0] {ST_IDLE, ST_LOOK, ST_READ} state_t;
  state_t state;

  logic [VA_W-1:0]  va_q;
  logic [OFF_W-1:0] size_mask, pte_off, pte_low;

  assign size_mask = (OFF_W'(1) << cfg_size_log2) - OFF_W'(1);
  assign pte_off   = OFF_W'({miss_va[OFF_W-1:PAGE_SHIFT], {PTE_SHIFT{1'b0}}}) & size_mask;
  assign pte_low   = cfg_base + pte_off;

  assign miss_ready = (state == ST_IDLE);
  assign lk_req     = (state == ST_LOOK);
  assign rd_req     = (state == ST_READ);
  assign ins_va     = va_q;
  assign flt_va     = va_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      va_q      <= '0;
      lk_va     <= '0;
      rd_addr   <= '0;
      ins_valid <= 1'b0;
      ins_pte   <= '0;
      flt_valid <= 1'b0;
      flt_cause <= '0;
    end else begin
      ins_valid <= 1'b0;
      flt_valid <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (miss_valid) begin
            va_q  <= miss_va;
            lk_va <= {miss_va[VA_W-1:OFF_W], pte_low};
            state <= ST_LOOK;
          end
        end
        ST_LOOK: begin
          if (lk_rsp_valid) begin
            if (lk_hit) begin
              rd_addr <= {lk_ppn, lk_va[PAGE_SHIFT-1:0]};
              state   <= ST_READ;
            end else begin
              flt_valid <= 1'b1;
              flt_cause <= CAUSE_NESTED;
              state     <= ST_IDLE;
            end
          end
        end
        ST_READ: begin
          if (rd_valid) begin
            if (rd_data[PRESENT_BIT]) begin
              ins_valid <= 1'b1;
              ins_pte   <= rd_data;
            end else begin
              flt_valid <= 1'b1;
              flt_cause <= CAUSE_ABSENT;
            end
            state <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/lpt_walker_chk.sv
module lpt_walker_chk #(
  parameter int VA_W        = 48,
  parameter int PTE_W       = 64,
  parameter int PRESENT_BIT = 0
) (
  input logic             clk,
  input logic             rst_n,
  input logic             miss_ready,
  input logic             lk_req,
  input logic [VA_W-1:0]  lk_va,
  input logic             lk_rsp_valid,
  input logic             lk_hit,
  input logic             rd_req,
  input logic             rd_valid,
  input logic [PTE_W-1:0] rd_data,
  input logic             ins_valid,
  input logic [PTE_W-1:0] ins_pte,
  input logic             flt_valid,
  input logic [1:0]       flt_cause
);

  AST_EXCL_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
    !(ins_valid && flt_valid)); // R9

  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_req || rd_req) |-> !miss_ready); // R8

  AST_LOOKUP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_req && !lk_rsp_valid) |=> (lk_req && $stable(lk_va))); // R10

  AST_NESTED_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_req && lk_rsp_valid && !lk_hit) |=> (flt_valid && flt_cause == 2'b01 && !rd_req)); // R4

  AST_READ_ON_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_req && lk_rsp_valid && lk_hit) |=> (rd_req && !flt_valid)); // R5

  AST_INSTALL_PRESENT: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && rd_valid && rd_data[PRESENT_BIT]) |=> (ins_valid && ins_pte == $past(rd_data))); // R6

  AST_ABSENT_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && rd_valid && !rd_data[PRESENT_BIT]) |=> (flt_valid && flt_cause == 2'b10 && !ins_valid)); // R7

endmodule

bind lpt_walker lpt_walker_chk #(.VA_W(VA_W), .PTE_W(PTE_W), .PRESENT_BIT(PRESENT_BIT)) u_chk (.*);

// File: tb/test_lpt_walker.sv
`timescale 1ns/1ps
module test_lpt_walker;

  localparam int VA_W = 48, OFF_W = 45, PAGE_SHIFT = 13, PA_W = 40, PPN_W = 27, PTE_W = 64;

  typedef struct {
    logic             hit;
    logic [PPN_W-1:0] ppn;
    logic [PTE_W-1:0] pte;
    int               ldly;
    int               rdly;
    logic [VA_W-1:0]  exp_lkva;
    logic [PA_W-1:0]  exp_rd;
    bit               trunc;
  } stim_t;

  typedef struct {
    bit               is_flt;
    logic [1:0]       cause;
    logic [VA_W-1:0]  va;
    logic [PTE_W-1:0] pte;
  } exp_t;

  logic clk = 1'b0, rst_n = 1'b0;
  logic miss_valid = 1'b0, miss_ready;
  logic [VA_W-1:0] miss_va = '0;
  logic [OFF_W-1:0] cfg_base = '0;
  logic [5:0] cfg_size_log2 = '0;
  logic lk_req, lk_rsp_valid, lk_hit;
  logic [VA_W-1:0] lk_va;
  logic [PPN_W-1:0] lk_ppn;
  logic rd_req, rd_valid;
  logic [PA_W-1:0] rd_addr;
  logic [PTE_W-1:0] rd_data;
  logic ins_valid, flt_valid;
  logic [VA_W-1:0] ins_va, flt_va;
  logic [PTE_W-1:0] ins_pte;
  logic [1:0] flt_cause;

  int nchk = 0, nerr = 0;
  stim_t lk_q[$];
  stim_t rd_q[$];
  exp_t  exp_q[$];

  always #4 clk = ~clk;

  lpt_walker i_lpt_walker (
    .clk(clk), .rst_n(rst_n), .miss_valid(miss_valid), .miss_ready(miss_ready), .miss_va(miss_va),
    .cfg_base(cfg_base), .cfg_size_log2(cfg_size_log2),
    .lk_req(lk_req), .lk_va(lk_va), .lk_rsp_valid(lk_rsp_valid), .lk_hit(lk_hit), .lk_ppn(lk_ppn),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_valid(rd_valid), .rd_data(rd_data),
    .ins_valid(ins_valid), .ins_va(ins_va), .ins_pte(ins_pte),
    .flt_valid(flt_valid), .flt_va(flt_va), .flt_cause(flt_cause)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  endtask

  task automatic send(input logic [VA_W-1:0] va, input logic hit, input logic [PPN_W-1:0] ppn,
                      input logic [PTE_W-1:0] pte, input int ld, input int rdl);
    stim_t s;
    exp_t e;
    logic [OFF_W-1:0] m, off;
    m = (cfg_size_log2 >= 6'd45) ? {OFF_W{1'b1}} : ((OFF_W'(1) << cfg_size_log2) - OFF_W'(1));
    off = {10'b0, va[44:13], 3'b000};
    s.hit = hit; s.ppn = ppn; s.pte = pte; s.ldly = ld; s.rdly = rdl;
    s.trunc = (off & ~m) != '0;
    s.exp_lkva = {va[47:45], cfg_base + (off & m)};
    s.exp_rd = {ppn, s.exp_lkva[PAGE_SHIFT-1:0]};
    e.va = va; e.pte = pte;
    e.is_flt = !hit || !pte[0];
    e.cause = !hit ? 2'b01 : 2'b10;
    lk_q.push_back(s);
    if (hit) rd_q.push_back(s);
    exp_q.push_back(e);
    @(negedge clk);
    miss_valid = 1'b1;
    miss_va = va;
    while (!miss_ready) @(negedge clk);
    @(posedge clk);
    #1 miss_valid = 1'b0;
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  // lookup responder
  initial begin
    stim_t s;
    lk_rsp_valid = 1'b0; lk_hit = 1'b0; lk_ppn = '0;
    forever begin
      @(negedge clk);
      if (rst_n && lk_req) begin
        if (lk_q.size() == 0) begin
          chk(1'b0, "R10 unexpected lookup", 64'(lk_va), 64'd0);
        end else begin
          s = lk_q.pop_front();
          chk(lk_va == s.exp_lkva, s.trunc ? "R3 truncated entry address" : "R2 entry address",
              64'(lk_va), 64'(s.exp_lkva));
          repeat (s.ldly) @(negedge clk);
          chk(lk_req && lk_va == s.exp_lkva, "R10 lookup held", 64'(lk_va), 64'(s.exp_lkva));
          lk_rsp_valid = 1'b1; lk_hit = s.hit; lk_ppn = s.ppn;
          @(negedge clk);
          lk_rsp_valid = 1'b0;
        end
      end
    end
  end

  // memory responder
  initial begin
    stim_t s;
    rd_valid = 1'b0; rd_data = '0;
    forever begin
      @(negedge clk);
      if (rst_n && rd_req) begin
        if (rd_q.size() == 0) begin
          chk(1'b0, "R4 read without hit", 64'(rd_addr), 64'd0);
        end else begin
          s = rd_q.pop_front();
          chk(rd_addr == s.exp_rd, "R5 physical read address", 64'(rd_addr), 64'(s.exp_rd));
          repeat (s.rdly) @(negedge clk);
          chk(rd_req && rd_addr == s.exp_rd, "R10 read held", 64'(rd_addr), 64'(s.exp_rd));
          rd_valid = 1'b1; rd_data = s.pte;
          @(negedge clk);
          rd_valid = 1'b0;
        end
      end
    end
  end

  // scoreboard monitor
  always @(negedge clk) begin
    exp_t e;
    if (rst_n) begin
      if (lk_req || rd_req)
        chk(!miss_ready, "R8 ready low while walking", 64'(miss_ready), 64'd0);
      if (ins_valid || flt_valid) begin
        chk(!(ins_valid && flt_valid), "R9 single outcome", {62'd0, ins_valid, flt_valid}, 64'd1);
        if (miss_valid)
          chk(miss_ready, "R8 ready in outcome cycle", 64'(miss_ready), 64'd1);
        if (exp_q.size() == 0) begin
          chk(1'b0, "R9 outcome without miss", {62'd0, ins_valid, flt_valid}, 64'd0);
        end else begin
          e = exp_q.pop_front();
          if (e.is_flt)
            chk(flt_valid && !ins_valid && flt_cause == e.cause && flt_va == e.va,
                e.cause == 2'b01 ? "R4 nested miss fault" : "R7 absent entry fault",
                {ins_valid, flt_valid, 12'd0, flt_cause, flt_va}, {2'b01, 12'd0, e.cause, e.va});
          else begin
            chk(ins_valid && !flt_valid && ins_va == e.va, "R6 install address",
                {ins_valid, flt_valid, 14'd0, ins_va}, {2'b10, 14'd0, e.va});
            chk(ins_pte == e.pte, "R6 install entry", ins_pte, e.pte);
          end
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog expired: actual=hung expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(miss_ready && !lk_req && !rd_req && !ins_valid && !flt_valid, "R1 reset state",
        {59'd0, miss_ready, lk_req, rd_req, ins_valid, flt_valid}, 64'h10);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(miss_ready && !lk_req && !rd_req && !ins_valid && !flt_valid, "R1 state after reset",
        {59'd0, miss_ready, lk_req, rd_req, ins_valid, flt_valid}, 64'h10);

    cfg_base = 45'h0001_0000_0000;
    cfg_size_log2 = 6'd23;
    send(48'h2000_0012_3456, 1'b1, 27'h0001234, 64'hABCD_0000_0000_0001, 1, 2);
    drain();
    send(48'hA000_7FFF_E000, 1'b1, 27'h7FFFFFF, 64'h0000_5555_0000_1001, 0, 0);
    drain();
    send(48'h4000_0000_2000, 1'b0, 27'h0, 64'h0, 2, 0);
    drain();
    send(48'h6000_0100_0000, 1'b1, 27'h00000AA, 64'hFFFF_FFFF_FFFF_FFFE, 0, 3);
    drain();

    cfg_size_log2 = 6'd13;
    send(48'h0000_2468_A000, 1'b1, 27'h0000011, 64'h1357_9BDF_0000_0003, 0, 1);
    drain();
    send(48'hE123_4567_8000, 1'b1, 27'h0000022, 64'h0000_0000_0000_0001, 1, 0);
    drain();

    cfg_size_log2 = 6'd50;
    cfg_base = 45'h0;
    send(48'h3FFF_FFFF_E000, 1'b1, 27'h0000033, 64'h0000_0000_0000_0011, 0, 0);
    drain();

    cfg_size_log2 = 6'd20;
    cfg_base = 45'h0000_0080_0000;
    send(48'h2000_0000_4000, 1'b1, 27'h0000101, 64'h0000_0000_0000_0101, 0, 0);
    send(48'h2000_0000_6000, 1'b0, 27'h0, 64'h0, 0, 0);
    send(48'h8000_0001_8000, 1'b1, 27'h0000102, 64'h0000_0000_0000_0100, 0, 0);
    send(48'h8000_0003_0000, 1'b1, 27'h0000103, 64'h0000_0000_0000_0F01, 0, 0);
    send(48'hC000_0000_0000, 1'b0, 27'h0, 64'h0, 0, 0);
    send(48'hC000_0000_2000, 1'b1, 27'h0000104, 64'h0000_0000_0000_7771, 0, 0);
    drain();

    chk(lk_q.size() == 0 && rd_q.size() == 0 && exp_q.size() == 0, "R9 all outcomes seen",
        64'(lk_q.size() + rd_q.size() + exp_q.size()), 64'd0);
    finish_run();
  end

endmodule